// File: doc/BRIEF.md
# Multi-lane serial flash protocol selector

This block keeps track of the lane arrangement used by a serial flash slave. There are three arrangements. In extended mode the command arrives on one line. In dual mode every phase uses two lines. In quad mode every phase uses four lines. The block tells the shifting datapath how many lanes to use for the command, address and data phases of each chip-select frame.

At reset the block takes a power-on default from two nonvolatile configuration bits. A volatile configuration write can override that default, and the override takes effect when the frame carrying the write ends. A rescue strobe returns the block to the default. While a program or erase is running with the high-voltage pin asserted, quad mode drops to extended lanes so that the host can suspend the operation or poll status. The block goes back to quad when the pin falls.

The controller is a four-state machine:
- `M_EXT`: extended lanes.
- `M_DUAL`: dual lanes.
- `M_QUAD`: quad lanes.
- `M_QHOLD`: quad is selected but extended lanes are in use because of a high-voltage operation.

The transitions are:
- commit: any state moves to the pending target once chip select is high.
- fallback: `M_QUAD` moves to `M_QHOLD`.
- resume: `M_QHOLD` moves to `M_QUAD`.
- reset load: the power-on default is loaded from the nonvolatile bits.

Top module: `flash_lane_sel`

## Requirements
- R1: During reset the mode is loaded from the nonvolatile bits. `nv_quad_n`=0 selects quad, and it wins when both bits are 0. Otherwise `nv_dual_n`=0 selects dual. Both bits at 1 select extended.
- R2: The lane outputs are encoded as 2'b00 = one lane, 2'b01 = two lanes and 2'b10 = four lanes. All three phase outputs carry the same code: extended gives 00, dual gives 01, quad gives 10.
- R3: A volatile write with `vcfg_sel[1]` (config bit 7) = 0 selects quad.
- R4: A volatile write with `vcfg_sel` = 2'b10 (bit 7 = 1, bit 6 = 0) selects dual.
- R5: A volatile write with `vcfg_sel` = 2'b11 returns the mode to the power-on default.
- R6: A volatile write is held pending and committed on the first clock edge at which `cs_n` is high. The lane outputs do not change while `cs_n` stays low.
- R7: A `rescue` pulse selects the power-on default and takes effect under the same chip-select rule. When `rescue` and a write arrive in the same cycle, the rescue wins.
- R8: In quad mode, with `cs_n` high, `hv_pin` and `pe_busy` both high switch the lanes to extended. The lanes return to quad on the first edge with `cs_n` high after `hv_pin` is low. The state stays in fallback while `hv_pin` is high, even after `pe_busy` falls.
- R9: `hv_pin` and `pe_busy` have no effect in dual or extended mode.
- R10: A `vcfg_wr` strobe sampled while `cs_n` is high is ignored.
- R11: A reset discards any volatile selection and reloads the nonvolatile default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, low for the length of a frame |
| nv_quad_n | input | 1 | Nonvolatile config bit 3, 0 = quad at power-on |
| nv_dual_n | input | 1 | Nonvolatile config bit 2, 0 = dual at power-on |
| vcfg_wr | input | 1 | One-cycle strobe: volatile config byte captured |
| vcfg_sel | input | 2 | Bits 7:6 of the volatile config byte |
| rescue | input | 1 | One-cycle strobe: rescue sequence detected |
| hv_pin | input | 1 | High-voltage program/erase pin level |
| pe_busy | input | 1 | Program or erase in progress |
| cmd_lanes | output | 2 | Command phase lane code |
| addr_lanes | output | 2 | Address phase lane code |
| data_lanes | output | 2 | Data phase lane code |

## Verification
The assertions assume three things about the inputs. `vcfg_wr` and `rescue` are single-cycle strobes. The nonvolatile bits stay constant while reset is asserted. `hv_pin` and `pe_busy` are synchronous to `clk`. The bench drives every input on the falling clock edge, so each one is settled well before the rising edge that samples it. It changes the nonvolatile bits only while reset is held. It raises each strobe for exactly one cycle.

// File: rtl/flash_lane_pkg.sv
package flash_lane_pkg;

    localparam int LANE_W = 2;

    typedef enum logic [1:0] {
        M_EXT   = 2'd0,
        M_DUAL  = 2'd1,
        M_QUAD  = 2'd2,
        M_QHOLD = 2'd3
    } mode_e;

    localparam logic [LANE_W-1:0] LN_ONE  = 2'b00;
    localparam logic [LANE_W-1:0] LN_TWO  = 2'b01;
    localparam logic [LANE_W-1:0] LN_FOUR = 2'b10;

    function automatic logic [LANE_W-1:0] lanes_of(input mode_e m);
        unique case (m)
            M_EXT:   lanes_of = LN_ONE;
            M_DUAL:  lanes_of = LN_TWO;
            M_QUAD:  lanes_of = LN_FOUR;
            M_QHOLD: lanes_of = LN_ONE;
        endcase
    endfunction

endpackage

// File: rtl/flash_lane_decode.sv
module flash_lane_decode
    import flash_lane_pkg::*;
(
    input  logic       nv_quad_n,
    input  logic       nv_dual_n,
    input  logic [1:0] vcfg_sel,
    output mode_e      dflt_mode,
    output mode_e      wr_mode
);

    // Power-on default: quad has priority over dual.
    always_comb begin
        if (!nv_quad_n)      dflt_mode = M_QUAD;
        else if (!nv_dual_n) dflt_mode = M_DUAL;
        else                 dflt_mode = M_EXT;
    end

    // Volatile write target, decoded from bits 7:6 of the config byte.
    always_comb begin
        unique case (vcfg_sel)
            2'b00, 2'b01: wr_mode = M_QUAD;
            2'b10:        wr_mode = M_DUAL;
            2'b11:        wr_mode = dflt_mode;
        endcase
    end

endmodule

// File: rtl/flash_lane_fsm.sv
module flash_lane_fsm
    import flash_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              vcfg_wr,
    input  logic              rescue,
    input  logic              hv_pin,
    input  logic              pe_busy,
    input  mode_e             dflt_mode,
    input  mode_e             wr_mode,
    output logic [LANE_W-1:0] cmd_lanes,
    output logic [LANE_W-1:0] addr_lanes,
    output logic [LANE_W-1:0] data_lanes
);

    mode_e state_q, state_nxt;
    mode_e pend_q, pend_nxt;
    logic  pend_vld_q, pend_vld_nxt;
    logic  req_vld;
    mode_e req_mode;
    logic  hv_op;

    assign hv_op    = hv_pin && pe_busy;
    assign req_vld  = rescue || pend_vld_q;
    assign req_mode = rescue ? dflt_mode : pend_q;

    always_comb begin
        state_nxt    = state_q;
        pend_nxt     = pend_q;
        pend_vld_nxt = pend_vld_q;
        if (cs_n) begin
            if (req_vld) begin
                // commit
                state_nxt    = (req_mode == M_QUAD && hv_op) ? M_QHOLD : req_mode;
                pend_vld_nxt = 1'b0;
            end else begin
                unique case (state_q)
                    M_QUAD:  if (hv_op)   state_nxt = M_QHOLD;  // fallback
                    M_QHOLD: if (!hv_pin) state_nxt = M_QUAD;   // resume
                    M_EXT, M_DUAL: state_nxt = state_q;
                endcase
            end
        end else if (rescue) begin
            pend_nxt     = dflt_mode;
            pend_vld_nxt = 1'b1;
        end else if (vcfg_wr) begin
            pend_nxt     = wr_mode;
            pend_vld_nxt = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= dflt_mode;
            pend_q     <= M_EXT;
            pend_vld_q <= 1'b0;
        end else begin
            state_q    <= state_nxt;
            pend_q     <= pend_nxt;
            pend_vld_q <= pend_vld_nxt;
        end
    end

    // Output register, loaded from the next state so lanes track commits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_lanes  <= lanes_of(dflt_mode);
            addr_lanes <= lanes_of(dflt_mode);
            data_lanes <= lanes_of(dflt_mode);
        end else begin
            cmd_lanes  <= lanes_of(state_nxt);
            addr_lanes <= lanes_of(state_nxt);
            data_lanes <= lanes_of(state_nxt);
        end
    end

    p_frame_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> (cs_n || $stable({cmd_lanes, addr_lanes, data_lanes})));

    p_pend_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && pend_vld_q) |=> !pend_vld_q);

    p_hold_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == M_QHOLD) |-> $past(hv_pin && pe_busy));

    p_hold_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == M_QHOLD) |-> $past(cs_n));

    p_dual_no_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_DUAL && cs_n && !rescue && !pend_vld_q) |=> state_q == M_DUAL);

endmodule

// File: rtl/flash_lane_sel.sv
module flash_lane_sel
    import flash_lane_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       nv_quad_n,
    input  logic       nv_dual_n,
    input  logic       vcfg_wr,
    input  logic [1:0] vcfg_sel,
    input  logic       rescue,
    input  logic       hv_pin,
    input  logic       pe_busy,
    output logic [1:0] cmd_lanes,
    output logic [1:0] addr_lanes,
    output logic [1:0] data_lanes
);

    mode_e dflt_mode;
    mode_e wr_mode;

    flash_lane_decode u_dec (
        .nv_quad_n (nv_quad_n),
        .nv_dual_n (nv_dual_n),
        .vcfg_sel  (vcfg_sel),
        .dflt_mode (dflt_mode),
        .wr_mode   (wr_mode)
    );

    flash_lane_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .vcfg_wr    (vcfg_wr),
        .rescue     (rescue),
        .hv_pin     (hv_pin),
        .pe_busy    (pe_busy),
        .dflt_mode  (dflt_mode),
        .wr_mode    (wr_mode),
        .cmd_lanes  (cmd_lanes),
        .addr_lanes (addr_lanes),
        .data_lanes (data_lanes)
    );

endmodule

// File: tb/flash_lane_sel_test.sv
module flash_lane_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       nv_quad_n = 1'b1;
    logic       nv_dual_n = 1'b1;
    logic       vcfg_wr = 1'b0;
    logic [1:0] vcfg_sel = 2'b11;
    logic       rescue = 1'b0;
    logic       hv_pin = 1'b0;
    logic       pe_busy = 1'b0;
    logic [1:0] cmd_lanes, addr_lanes, data_lanes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [1:0] L1 = 2'b00, L2 = 2'b01, L4 = 2'b10;

    // {vcfg bits 7:6, expected lanes}; default is extended (nv = 1,1)
    localparam int NVEC = 7;
    localparam logic [3:0] VECS [NVEC] = '{
        {2'b01, L4}, {2'b10, L2}, {2'b11, L1}, {2'b00, L4},
        {2'b10, L2}, {2'b01, L4}, {2'b11, L1}
    };

    always #10 clk = ~clk;

    flash_lane_sel uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .nv_quad_n(nv_quad_n), .nv_dual_n(nv_dual_n),
        .vcfg_wr(vcfg_wr), .vcfg_sel(vcfg_sel), .rescue(rescue),
        .hv_pin(hv_pin), .pe_busy(pe_busy),
        .cmd_lanes(cmd_lanes), .addr_lanes(addr_lanes), .data_lanes(data_lanes)
    );

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (cmd_lanes !== exp || addr_lanes !== exp || data_lanes !== exp) begin
            errors++;
            $display("FAIL %s: lanes cmd=%b addr=%b data=%b expected %b",
                     req, cmd_lanes, addr_lanes, data_lanes, exp);
        end
    endtask

    task automatic do_reset(input logic q_n, input logic d_n);
        @(negedge clk);
        rst_n = 1'b0; nv_quad_n = q_n; nv_dual_n = d_n;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic vwrite(input logic [1:0] sel);
        cs_n = 1'b0;
        @(negedge clk);
        vcfg_wr = 1'b1; vcfg_sel = sel;
        @(negedge clk);
        vcfg_wr = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_rescue();
        rescue = 1'b1;
        @(negedge clk);
        rescue = 1'b0;
    endtask

    initial begin
        // R1: power-on defaults
        do_reset(1'b1, 1'b1); check("R1 both bits high -> extended", L1);
        do_reset(1'b0, 1'b1); check("R1 bit3 low -> quad", L4);
        do_reset(1'b1, 1'b0); check("R1 bit2 low -> dual", L2);
        do_reset(1'b0, 1'b0); check("R1 both low -> quad priority", L4);

        // R2/R3/R4/R5: table of volatile writes
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < NVEC; i++) begin
            vwrite(VECS[i][3:2]);
            check("R2/R3/R4/R5 table write", VECS[i][1:0]);
        end

        // R5 with a dual default
        do_reset(1'b1, 1'b0);
        vwrite(2'b01); check("R3 quad over dual default", L4);
        vwrite(2'b11); check("R5 back to dual default", L2);

        // R11: reset drops volatile selection
        vwrite(2'b01);
        do_reset(1'b1, 1'b0); check("R11 reset reloads dual", L2);

        // R6: no change mid-frame
        do_reset(1'b1, 1'b1);
        cs_n = 1'b0;
        @(negedge clk);
        vcfg_wr = 1'b1; vcfg_sel = 2'b10;
        @(negedge clk);
        vcfg_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 held during frame", L1);
        cs_n = 1'b1;
        @(negedge clk);
        check("R6 committed after frame", L2);

        // R10: strobe while deselected ignored
        vcfg_wr = 1'b1; vcfg_sel = 2'b01;
        @(negedge clk);
        vcfg_wr = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 write with cs high ignored", L2);

        // R7: rescue
        pulse_rescue(); check("R7 rescue to default", L1);
        vwrite(2'b01); check("R3 quad before rescue test", L4);
        cs_n = 1'b0;
        @(negedge clk);
        pulse_rescue();
        @(negedge clk);
        check("R7 rescue waits for frame end", L4);
        cs_n = 1'b1;
        @(negedge clk);
        check("R7 rescue applied after frame", L1);
        cs_n = 1'b0;
        @(negedge clk);
        vcfg_wr = 1'b1; vcfg_sel = 2'b01; rescue = 1'b1;
        @(negedge clk);
        vcfg_wr = 1'b0; rescue = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        check("R7 rescue beats same-cycle write", L1);

        // R8: high-voltage fallback
        vwrite(2'b01); check("R8 quad selected", L4);
        hv_pin = 1'b1; pe_busy = 1'b1;
        @(negedge clk);
        check("R8 fallback to extended", L1);
        pe_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 stays fallback while pin high", L1);
        hv_pin = 1'b0;
        @(negedge clk);
        check("R8 resume quad", L4);
        cs_n = 1'b0; hv_pin = 1'b1; pe_busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 no fallback mid-frame", L4);
        cs_n = 1'b1;
        @(negedge clk);
        check("R8 fallback after frame", L1);
        hv_pin = 1'b0; pe_busy = 1'b0;
        @(negedge clk);
        check("R8 resume after pin low", L4);

        // R9: no fallback in dual / extended
        vwrite(2'b10);
        hv_pin = 1'b1; pe_busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 dual ignores hv", L2);
        vwrite(2'b11);
        repeat (2) @(negedge clk);
        check("R9 extended ignores hv", L1);
        hv_pin = 1'b0; pe_busy = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule